// File: doc/BRIEF.md
# Keyboard/Auxiliary Controller Host Port

This block is the processor-facing front end of a two-link serial input controller (keyboard plus one auxiliary pointing device). The host sees two byte-wide addresses, selected by `hst_cmd_sel_i`. Port 0 is the data port: a read returns the output buffer and a write fills the input buffer as data. Port 1 is the command/status port: a read returns the status byte and a write fills the input buffer as a command. The block holds the controller configuration byte, a 32-entry internal byte store, the output-port register, and the output buffer. The output buffer is tagged with the source of its byte and drives one of two interrupt lines.

Commands are decoded when the core consumes the input buffer. Some commands return a byte through the output buffer. Others arm a follow-on action for the next data-port byte: a store write, an output-port write, byte injection, or transmission to the auxiliary device. A command with the high nibble F pulses chosen low output-port bits low for a fixed time.

Received device bytes arrive from the two link transceivers with a valid/acknowledge pair and error flags. A data-port byte with nothing armed is sent to the keyboard transceiver. The password filter only reports whether secure mode is active.

Top module: `kbc_host_port`

## Requirements
- R1: After reset, the output port reads 0x03: address-20 gate (bit 1) high and processor reset (bit 0) released. The configuration byte is 0x00, so the system flag is 0. Status reads 0x10 when the filter is not secure, and both interrupts and both inhibits are low.
- R2: Status bits 7..0 are: parity error, time-out, auxiliary-source, not-secure, last-write-was-command, system flag, input full, output full. A command-port write sets bit 3 and a data-port write clears it. Either write sets bit 1, which clears when the core consumes the byte. Bit 2 copies configuration bit 2, and bit 4 is the inverse of `pw_secure_i`.
- R3: A data-port read clears output-full (bit 0), the auxiliary-source bit (bit 5) and both interrupts. Bit 5 is set only while the buffered byte came from the auxiliary side.
- R4: Command 0x20|a returns the store entry at the low five bits a. Command 0x60|a writes entry a with the next data byte. Entry 0 is the configuration byte, and its bits 7 and 3 always read 0.
- R5: Commands 0xA7/0xA8 set/clear configuration bit 5 (auxiliary disable), and 0xAD/0xAE set/clear bit 4 (keyboard disable). A disabled link is inhibited and its received bytes are never acknowledged.
- R6: Command 0xC0 returns {6'b0, link data lines}. Command 0xD0 returns the output-port register. Command 0xD1 loads that register from the next data byte.
- R7: Commands 0xD2/0xD3 place the next data byte in the output buffer tagged as keyboard or auxiliary.
- R8: Command 0xD4 sends the next data byte to the auxiliary transmitter. A data byte with no armed command goes to the keyboard transmitter. At most one transmit strobe is active at a time.
- R9: Command 0xF0..0xFF drives low, for PULSE_CYCLES clocks, every output-port bit 3..0 whose command bit is 0. After that the register value returns.
- R10: IRQ1 rises when a keyboard or command-response byte is loaded while configuration bit 0 is 1. IRQ12 rises for an auxiliary byte while bit 1 is 1.
- R11: An enabled link's byte is taken only when the output buffer is empty, and the keyboard wins ties. A byte flagged with a parity error or time-out is replaced by 0xFF, with status bit 7 or 6 set until the next load.
- R12: While the output buffer is full, both links are inhibited, no device byte is taken, and the input buffer is not consumed.
- R13: A command written while a follow-on byte is armed cancels the armed action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_wr_i | input | 1 | Host write strobe |
| hst_rd_i | input | 1 | Host read strobe |
| hst_cmd_sel_i | input | 1 | 1 = command/status port, 0 = data port |
| hst_wdata_i | input | 8 | Host write byte |
| hst_rdata_o | output | 8 | Status or output buffer |
| irq1_o | output | 1 | Keyboard/command interrupt |
| irq12_o | output | 1 | Auxiliary interrupt |
| kbd_rx_valid_i | input | 1 | Keyboard byte available (held until ack) |
| kbd_rx_byte_i | input | 8 | Keyboard received byte |
| kbd_rx_perr_i | input | 1 | Keyboard byte parity error |
| kbd_rx_tmo_i | input | 1 | Keyboard receive time-out |
| kbd_rx_ack_o | output | 1 | Keyboard byte taken this cycle |
| aux_rx_valid_i | input | 1 | Auxiliary byte available |
| aux_rx_byte_i | input | 8 | Auxiliary received byte |
| aux_rx_perr_i | input | 1 | Auxiliary parity error |
| aux_rx_tmo_i | input | 1 | Auxiliary time-out |
| aux_rx_ack_o | output | 1 | Auxiliary byte taken this cycle |
| kbd_tx_valid_o | output | 1 | Send tx_byte_o to keyboard |
| aux_tx_valid_o | output | 1 | Send tx_byte_o to auxiliary device |
| tx_byte_o | output | 8 | Byte to transmit |
| kbd_inhibit_o | output | 1 | Hold keyboard clock low |
| aux_inhibit_o | output | 1 | Hold auxiliary clock low |
| pw_secure_i | input | 1 | Password filter in secure mode |
| link_data_i | input | 2 | Data line levels, bit 1 auxiliary, bit 0 keyboard |
| out_port_o | output | 8 | Output port with pulses applied |

## Verification
The bench drives the host port into its contested corners. A command is written while the output buffer is still full, and it must wait: a decoder that ran it early would overwrite the unread byte. Both links present bytes in the same cycle: one that was not keyboard-first, or that took both, would lose or reorder a byte. A pending 0xD2 is cancelled by a later command: a design that kept it would inject the next data byte instead of transmitting it. Error bytes, disabled-link holds, interrupt gating and the timed pulse are checked at the ports: a wrong pulse length or mask shows as a stale output-port value.

// File: rtl/kbc_host_pkg.sv
package kbc_host_pkg;
  typedef enum logic [2:0] {
    PEND_NONE, PEND_RAM, PEND_OUTP, PEND_KOB, PEND_AOB, PEND_AUX_TX
  } pend_e;

  localparam logic [7:0] CB_WMASK = 8'h77;  // bits 7 and 3 reserved
  localparam logic [7:0] ERR_BYTE = 8'hFF;
  localparam int CB_AUXDIS = 5;
  localparam int CB_KBDDIS = 4;
  localparam int CB_SYS    = 2;
  localparam int CB_AUXIE  = 1;
  localparam int CB_KBDIE  = 0;
endpackage

// File: rtl/kbc_ibuf.sv
module kbc_ibuf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          consume_i,
  output logic          full_o,
  output logic          is_cmd_o,
  output logic [DW-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o   <= 1'b0;
      is_cmd_o <= 1'b0;
      byte_o   <= '0;
    end else if (wr_i) begin
      full_o   <= 1'b1;
      is_cmd_o <= sel_cmd_i;
      byte_o   <= wdata_i;
    end else if (consume_i) begin
      full_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec
  import kbc_host_pkg::*;
#(
  parameter int         RAM_AW   = 5,
  parameter logic [7:0] OUTP_RST = 8'h03,
  parameter logic [7:0] CB_RST   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ibuf_full_i,
  input  logic       ibuf_cmd_i,
  input  logic [7:0] ibuf_byte_i,
  input  logic       go_i,
  input  logic [1:0] link_data_i,
  output logic       consume_o,
  output logic       resp_valid_o,
  output logic [7:0] resp_byte_o,
  output logic       resp_aux_o,
  output logic       kbd_tx_valid_o,
  output logic       aux_tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic [4:0] cb_flags_o,
  output logic [7:0] out_reg_o,
  output logic       pulse_start_o,
  output logic [3:0] pulse_mask_o
);
  localparam int RAM_N = 1 << RAM_AW;

  pend_e             pend_q, pend_d;
  logic [RAM_AW-1:0] waddr_q, waddr_d;
  logic [7:0]        cb_q, cb_d;
  logic [7:0]        outp_q, outp_d;
  logic [7:0]        ram_q [RAM_N];
  logic              ram_we;
  logic [RAM_AW-1:0] addr;

  assign addr      = ibuf_byte_i[RAM_AW-1:0];
  assign consume_o = ibuf_full_i & go_i;
  assign tx_byte_o = ibuf_byte_i;

  always_comb begin
    pend_d         = pend_q;
    waddr_d        = waddr_q;
    cb_d           = cb_q;
    outp_d         = outp_q;
    ram_we         = 1'b0;
    resp_valid_o   = 1'b0;
    resp_byte_o    = '0;
    resp_aux_o     = 1'b0;
    kbd_tx_valid_o = 1'b0;
    aux_tx_valid_o = 1'b0;
    pulse_start_o  = 1'b0;
    pulse_mask_o   = '0;
    if (consume_o) begin
      if (ibuf_cmd_i) begin
        pend_d = PEND_NONE;  // a new command cancels any armed follow-on
        if (ibuf_byte_i[7:5] == 3'b001) begin
          resp_valid_o = 1'b1;
          resp_byte_o  = (addr == '0) ? cb_q : ram_q[addr];
        end else if (ibuf_byte_i[7:5] == 3'b011) begin
          pend_d  = PEND_RAM;
          waddr_d = addr;
        end else if (ibuf_byte_i[7:4] == 4'hF) begin
          pulse_start_o = 1'b1;
          pulse_mask_o  = ~ibuf_byte_i[3:0];
        end else begin
          case (ibuf_byte_i)
            8'hA7: cb_d[CB_AUXDIS] = 1'b1;
            8'hA8: cb_d[CB_AUXDIS] = 1'b0;
            8'hAD: cb_d[CB_KBDDIS] = 1'b1;
            8'hAE: cb_d[CB_KBDDIS] = 1'b0;
            8'hC0: begin
              resp_valid_o = 1'b1;
              resp_byte_o  = {6'b0, link_data_i};
            end
            8'hD0: begin
              resp_valid_o = 1'b1;
              resp_byte_o  = outp_q;
            end
            8'hD1: pend_d = PEND_OUTP;
            8'hD2: pend_d = PEND_KOB;
            8'hD3: pend_d = PEND_AOB;
            8'hD4: pend_d = PEND_AUX_TX;
            default: ;
          endcase
        end
      end else begin
        pend_d = PEND_NONE;
        case (pend_q)
          PEND_RAM: begin
            if (waddr_q == '0) cb_d = ibuf_byte_i & CB_WMASK;
            else               ram_we = 1'b1;
          end
          PEND_OUTP: outp_d = ibuf_byte_i;
          PEND_KOB: begin
            resp_valid_o = 1'b1;
            resp_byte_o  = ibuf_byte_i;
          end
          PEND_AOB: begin
            resp_valid_o = 1'b1;
            resp_byte_o  = ibuf_byte_i;
            resp_aux_o   = 1'b1;
          end
          PEND_AUX_TX: aux_tx_valid_o = 1'b1;
          default:     kbd_tx_valid_o = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= PEND_NONE;
      waddr_q <= '0;
      cb_q    <= CB_RST & CB_WMASK;
      outp_q  <= OUTP_RST;
      for (int i = 0; i < RAM_N; i++) ram_q[i] <= '0;
    end else begin
      pend_q  <= pend_d;
      waddr_q <= waddr_d;
      cb_q    <= cb_d;
      outp_q  <= outp_d;
      if (ram_we) ram_q[waddr_q] <= ibuf_byte_i;
    end
  end

  assign cb_flags_o = {cb_q[CB_AUXDIS], cb_q[CB_KBDDIS], cb_q[CB_SYS],
                       cb_q[CB_AUXIE], cb_q[CB_KBDIE]};
  assign out_reg_o  = outp_q;
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf
  import kbc_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       resp_valid_i,
  input  logic [7:0] resp_byte_i,
  input  logic       resp_aux_i,
  input  logic [1:0] rx_valid_i,   // [1] aux, [0] keyboard
  input  logic [7:0] rx_byte_i [2],
  input  logic [1:0] rx_perr_i,
  input  logic [1:0] rx_tmo_i,
  input  logic [1:0] link_en_i,
  input  logic [1:0] irq_en_i,
  output logic [1:0] rx_ack_o,
  output logic       dev_take_o,
  output logic [7:0] byte_o,
  output logic       full_o,
  output logic       aux_o,
  output logic       perr_o,
  output logic       tmo_o,
  output logic [1:0] irq_o         // [1] IRQ12, [0] IRQ1
);
  logic [1:0] can_take;
  logic       sel;  // winning link

  for (genvar g = 0; g < 2; g++) begin : g_link
    assign can_take[g] = rx_valid_i[g] & link_en_i[g] & ~full_o;
  end

  // keyboard wins ties
  assign rx_ack_o   = {can_take[1] & ~can_take[0], can_take[0]};
  assign dev_take_o = |can_take;
  assign sel        = ~can_take[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      full_o <= 1'b0;
      aux_o  <= 1'b0;
      perr_o <= 1'b0;
      tmo_o  <= 1'b0;
      irq_o  <= '0;
    end else if (dev_take_o) begin
      byte_o <= (rx_perr_i[sel] | rx_tmo_i[sel]) ? ERR_BYTE : rx_byte_i[sel];
      full_o <= 1'b1;
      aux_o  <= sel;
      perr_o <= rx_perr_i[sel];
      tmo_o  <= rx_tmo_i[sel];
      irq_o  <= sel ? {irq_en_i[1], 1'b0} : {1'b0, irq_en_i[0]};
    end else if (resp_valid_i) begin
      byte_o <= resp_byte_i;
      full_o <= 1'b1;
      aux_o  <= resp_aux_i;
      perr_o <= 1'b0;
      tmo_o  <= 1'b0;
      irq_o  <= resp_aux_i ? {irq_en_i[1], 1'b0} : {1'b0, irq_en_i[0]};
    end else if (rd_i) begin
      full_o <= 1'b0;
      aux_o  <= 1'b0;
      irq_o  <= '0;
    end
  end
endmodule

// File: rtl/kbc_pulse.sv
module kbc_pulse #(
  parameter int CYCLES = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [3:0] mask_i,
  output logic       busy_o,
  output logic [3:0] mask_o
);
  localparam int             CW   = $clog2(CYCLES + 1);
  localparam logic [CW-1:0]  LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mask_o <= '0;
    end else if (start_i) begin
      cnt_q  <= LOAD;
      mask_o <= mask_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port #(
  parameter int         PULSE_CYCLES = 300,
  parameter int         RAM_AW       = 5,
  parameter logic [7:0] OUTP_RST     = 8'h03
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hst_wr_i,
  input  logic       hst_rd_i,
  input  logic       hst_cmd_sel_i,
  input  logic [7:0] hst_wdata_i,
  output logic [7:0] hst_rdata_o,
  output logic       irq1_o,
  output logic       irq12_o,
  input  logic       kbd_rx_valid_i,
  input  logic [7:0] kbd_rx_byte_i,
  input  logic       kbd_rx_perr_i,
  input  logic       kbd_rx_tmo_i,
  output logic       kbd_rx_ack_o,
  input  logic       aux_rx_valid_i,
  input  logic [7:0] aux_rx_byte_i,
  input  logic       aux_rx_perr_i,
  input  logic       aux_rx_tmo_i,
  output logic       aux_rx_ack_o,
  output logic       kbd_tx_valid_o,
  output logic       aux_tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       kbd_inhibit_o,
  output logic       aux_inhibit_o,
  input  logic       pw_secure_i,
  input  logic [1:0] link_data_i,
  output logic [7:0] out_port_o
);
  logic       ib_full, ib_cmd, consume;
  logic [7:0] ib_byte;
  logic       resp_valid, resp_aux;
  logic [7:0] resp_byte;
  logic [4:0] cb_flags;   // {auxdis, kbddis, sys, auxie, kbdie}
  logic [7:0] out_reg;
  logic       pulse_start, pulse_busy;
  logic [3:0] pulse_mask_d, pulse_mask_q;
  logic       ob_full, ob_aux, ob_perr, ob_tmo, dev_take;
  logic [7:0] ob_byte;
  logic [1:0] rx_ack, irq;
  logic [7:0] rx_bytes [2];
  logic [7:0] status_w;
  logic       go;

  assign go = ~ob_full & ~dev_take & ~pulse_busy;

  kbc_ibuf #(.DW(8)) i_ibuf (
    .clk_i, .rst_ni,
    .wr_i      (hst_wr_i),
    .sel_cmd_i (hst_cmd_sel_i),
    .wdata_i   (hst_wdata_i),
    .consume_i (consume),
    .full_o    (ib_full),
    .is_cmd_o  (ib_cmd),
    .byte_o    (ib_byte)
  );

  kbc_cmd_dec #(.RAM_AW(RAM_AW), .OUTP_RST(OUTP_RST), .CB_RST(8'h00)) i_dec (
    .clk_i, .rst_ni,
    .ibuf_full_i    (ib_full),
    .ibuf_cmd_i     (ib_cmd),
    .ibuf_byte_i    (ib_byte),
    .go_i           (go),
    .link_data_i    (link_data_i),
    .consume_o      (consume),
    .resp_valid_o   (resp_valid),
    .resp_byte_o    (resp_byte),
    .resp_aux_o     (resp_aux),
    .kbd_tx_valid_o (kbd_tx_valid_o),
    .aux_tx_valid_o (aux_tx_valid_o),
    .tx_byte_o      (tx_byte_o),
    .cb_flags_o     (cb_flags),
    .out_reg_o      (out_reg),
    .pulse_start_o  (pulse_start),
    .pulse_mask_o   (pulse_mask_d)
  );

  assign rx_bytes[0] = kbd_rx_byte_i;
  assign rx_bytes[1] = aux_rx_byte_i;

  kbc_obuf i_obuf (
    .clk_i, .rst_ni,
    .rd_i         (hst_rd_i & ~hst_cmd_sel_i),
    .resp_valid_i (resp_valid),
    .resp_byte_i  (resp_byte),
    .resp_aux_i   (resp_aux),
    .rx_valid_i   ({aux_rx_valid_i, kbd_rx_valid_i}),
    .rx_byte_i    (rx_bytes),
    .rx_perr_i    ({aux_rx_perr_i, kbd_rx_perr_i}),
    .rx_tmo_i     ({aux_rx_tmo_i, kbd_rx_tmo_i}),
    .link_en_i    (~cb_flags[4:3]),
    .irq_en_i     (cb_flags[1:0]),
    .rx_ack_o     (rx_ack),
    .dev_take_o   (dev_take),
    .byte_o       (ob_byte),
    .full_o       (ob_full),
    .aux_o        (ob_aux),
    .perr_o       (ob_perr),
    .tmo_o        (ob_tmo),
    .irq_o        (irq)
  );

  kbc_pulse #(.CYCLES(PULSE_CYCLES)) i_pulse (
    .clk_i, .rst_ni,
    .start_i (pulse_start),
    .mask_i  (pulse_mask_d),
    .busy_o  (pulse_busy),
    .mask_o  (pulse_mask_q)
  );

  assign kbd_rx_ack_o  = rx_ack[0];
  assign aux_rx_ack_o  = rx_ack[1];
  assign irq1_o        = irq[0];
  assign irq12_o       = irq[1];
  assign kbd_inhibit_o = cb_flags[3] | ob_full;
  assign aux_inhibit_o = cb_flags[4] | ob_full;

  assign status_w = {ob_perr, ob_tmo, ob_aux, ~pw_secure_i,
                     ib_cmd, cb_flags[2], ib_full, ob_full};
  assign hst_rdata_o = hst_cmd_sel_i ? status_w : ob_byte;
  assign out_port_o  = {out_reg[7:4],
                        out_reg[3:0] & ~(pulse_busy ? pulse_mask_q : 4'h0)};
endmodule

// File: rtl/kbc_host_port_chk.sv
module kbc_host_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hst_wr_i,
  input logic       hst_rd_i,
  input logic       hst_cmd_sel_i,
  input logic [7:0] status_i,
  input logic       kbdie_i,
  input logic       irq1_o,
  input logic       irq12_o,
  input logic       kbd_rx_ack_o,
  input logic       aux_rx_ack_o,
  input logic       kbd_inhibit_o,
  input logic       aux_inhibit_o,
  input logic       kbd_tx_valid_o,
  input logic       aux_tx_valid_o
);
  a_r2_ibf_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_wr_i |=> status_i[1] && (status_i[3] == $past(hst_cmd_sel_i)));

  a_r3_obf_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_rd_i && !hst_cmd_sel_i && status_i[0]) |=> !status_i[0] && !irq1_o && !irq12_o);

  a_r10_irq1_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq1_o) |-> $past(kbdie_i));

  a_r10_irq12_aux_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq12_o |-> status_i[5] && status_i[0]);

  a_r5_kbd_ack_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_rx_ack_o |-> !kbd_inhibit_o);

  a_r5_aux_ack_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_rx_ack_o |-> !aux_inhibit_o);

  a_r11_single_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kbd_rx_ack_o, aux_rx_ack_o}));

  a_r12_take_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbd_rx_ack_o || aux_rx_ack_o) |=> status_i[0]);

  a_r8_tx_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kbd_tx_valid_o, aux_tx_valid_o}));
endmodule

bind kbc_host_port kbc_host_port_chk i_chk (
  .clk_i, .rst_ni, .hst_wr_i, .hst_rd_i, .hst_cmd_sel_i,
  .status_i (status_w),
  .kbdie_i  (cb_flags[0]),
  .irq1_o, .irq12_o, .kbd_rx_ack_o, .aux_rx_ack_o,
  .kbd_inhibit_o, .aux_inhibit_o, .kbd_tx_valid_o, .aux_tx_valid_o
);

// File: tb/test_kbc_host_port.sv
`timescale 1ns/1ps
module test_kbc_host_port;
  localparam int PULSE = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 0, hst_rd = 0, hst_sel = 0;
  logic [7:0] hst_wdata = '0, hst_rdata;
  logic irq1, irq12;
  logic kv = 0, kp = 0, kt = 0, av = 0, ap = 0, at = 0;
  logic [7:0] kb = '0, ab = '0;
  logic kack, aack, ktx, atx, kinh, ainh, secure = 0;
  logic [7:0] txb, outp;

  int nchk = 0, nfail = 0, kcnt = 0, acnt = 0;
  logic [7:0] klast = '0, alast = '0, rd_v;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  kbc_host_port #(.PULSE_CYCLES(PULSE)) i_kbc_host_port (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_wr_i(hst_wr), .hst_rd_i(hst_rd), .hst_cmd_sel_i(hst_sel),
    .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata),
    .irq1_o(irq1), .irq12_o(irq12),
    .kbd_rx_valid_i(kv), .kbd_rx_byte_i(kb), .kbd_rx_perr_i(kp), .kbd_rx_tmo_i(kt),
    .kbd_rx_ack_o(kack),
    .aux_rx_valid_i(av), .aux_rx_byte_i(ab), .aux_rx_perr_i(ap), .aux_rx_tmo_i(at),
    .aux_rx_ack_o(aack),
    .kbd_tx_valid_o(ktx), .aux_tx_valid_o(atx), .tx_byte_o(txb),
    .kbd_inhibit_o(kinh), .aux_inhibit_o(ainh),
    .pw_secure_i(secure), .link_data_i(2'b10), .out_port_o(outp)
  );

  always @(negedge clk) begin
    if (ktx) begin kcnt++; klast = txb; end
    if (atx) begin acnt++; alast = txb; end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); hst_sel = sel; hst_wdata = d; hst_wr = 1;
    @(negedge clk); hst_wr = 0; hst_sel = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); hst_sel = sel; hst_rd = 1;
    #1 d = hst_rdata;
    @(negedge clk); hst_rd = 0; hst_sel = 0;
  endtask

  task automatic stat(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(1'b1, v);
    check(tag, v, exp);
  endtask

  task automatic data(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(1'b0, v);
    check(tag, v, exp);
    repeat (2) @(negedge clk);
  endtask

  // {op, req, byte, expected}; op 0 cmd write, 1 data write, 2 data read, 3 status read
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    24'h0_4_60_00, 24'h1_4_FF_00, 24'h0_4_20_00, 24'h2_4_00_77,  // R4 reserved bits
    24'h0_4_65_00, 24'h1_4_A5_00, 24'h0_4_25_00, 24'h2_4_00_A5,  // R4 store entry
    24'h0_5_A8_00, 24'h0_5_AE_00, 24'h0_5_20_00, 24'h2_5_00_47,  // R5
    24'h0_7_D2_00, 24'h1_7_3C_00, 24'h3_3_00_15, 24'h2_7_00_3C,  // R7, R3
    24'h0_7_D3_00, 24'h1_7_C3_00, 24'h3_3_00_35, 24'h2_7_00_C3,  // R7, R3 aux bit
    24'h0_6_D1_00, 24'h1_6_F3_00, 24'h0_6_D0_00, 24'h2_6_00_F3,  // R6
    24'h0_6_C0_00, 24'h2_6_00_02, 24'h3_2_00_1C                  // R6, R2
  };

  initial begin
    #(20 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    stat("R1 status", 8'h10);
    check("R1 out_port", outp, 8'h03);
    check("R1 irq/inhibit", {4'b0, irq1, irq12, kinh, ainh}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][19:16], i);
      case (VEC[i][23:20])
        4'h0: bus_wr(1'b1, VEC[i][15:8]);
        4'h1: bus_wr(1'b0, VEC[i][15:8]);
        4'h2: begin bus_rd(1'b0, v); check(tag, v, VEC[i][7:0]); repeat (2) @(negedge clk); end
        default: begin bus_rd(1'b1, v); check(tag, v, VEC[i][7:0]); end
      endcase
    end

    // R10 / R12: command waits behind an unread byte
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h11);
    check("R10 irq1 kbd inject", {6'b0, irq12, irq1}, 8'h01);
    bus_wr(1'b1, 8'h20);
    stat("R2 R12 cmd stalled", 8'h1F);
    data("R3 first byte", 8'h11);
    data("R12 deferred response", 8'h47);

    // R2 / R8: data byte stalled then sent to keyboard
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h11);
    bus_wr(1'b0, 8'h99);
    stat("R2 data flag", 8'h17);
    check("R12 no tx while full", 8'(kcnt), 8'd0);
    data("R3 inject", 8'h11);
    check("R8 kbd tx count", 8'(kcnt), 8'd1);
    check("R8 kbd tx byte", klast, 8'h99);

    bus_wr(1'b1, 8'hD4); bus_wr(1'b0, 8'h5A);
    check("R8 aux tx count", 8'(acnt), 8'd1);
    check("R8 aux tx byte", alast, 8'h5A);
    check("R8 kbd unchanged", 8'(kcnt), 8'd1);

    // R11 / R12: both links at once
    @(negedge clk); kb = 8'h1C; kv = 1; ab = 8'h2D; av = 1;
    @(posedge clk); #1 kv = 0;
    @(negedge clk);
    check("R12 aux held", {6'b0, aack, ainh}, 8'h01);
    stat("R11 kbd status", 8'h15);
    check("R10 irq kbd", {6'b0, irq12, irq1}, 8'h01);
    bus_rd(1'b0, rd_v); check("R11 kbd first", rd_v, 8'h1C);
    @(posedge clk); #1 av = 0;
    @(negedge clk);
    stat("R3 aux status", 8'h35);
    check("R10 irq aux", {6'b0, irq12, irq1}, 8'h02);
    data("R11 aux second", 8'h2D);

    // R11 error substitution
    @(negedge clk); kb = 8'h12; kp = 1; kv = 1;
    @(posedge clk); #1 kv = 0; kp = 0;
    @(negedge clk);
    stat("R11 parity status", 8'h95);
    data("R11 parity byte", 8'hFF);
    @(negedge clk); ab = 8'h34; at = 1; av = 1;
    @(posedge clk); #1 av = 0; at = 0;
    @(negedge clk);
    stat("R11 timeout status", 8'h75);
    data("R11 timeout byte", 8'hFF);

    // R5 disabled keyboard link
    bus_wr(1'b1, 8'hAD);
    check("R5 kbd inhibit", {7'b0, kinh}, 8'h01);
    @(negedge clk); kb = 8'h21; kv = 1;
    repeat (5) @(negedge clk);
    check("R5 no ack", {7'b0, kack}, 8'h00);
    stat("R5 nothing taken", 8'h5C);
    bus_wr(1'b1, 8'hAE);
    kv = 0;
    data("R5 taken after enable", 8'h21);

    // R9 pulse
    bus_wr(1'b1, 8'hF0);
    check("R9 pulse low", outp, 8'hF0);
    repeat (PULSE + 10) @(negedge clk);
    check("R9 pulse end", outp, 8'hF3);

    // R13 cancel
    bus_wr(1'b1, 8'hD2); bus_wr(1'b1, 8'h20);
    data("R13 cancelled", 8'h47);
    bus_wr(1'b0, 8'h44);
    stat("R13 no inject", 8'h14);
    check("R13 sent to kbd", klast, 8'h44);

    // R4 / R10: config cleared
    bus_wr(1'b1, 8'h60); bus_wr(1'b0, 8'h00);
    stat("R4 sysflag off", 8'h10);
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h66);
    check("R10 irq disabled", {6'b0, irq12, irq1}, 8'h00);
    data("R7 inject", 8'h66);

    // R2 secure mode clears bit 4
    secure = 1;
    @(negedge clk);
    stat("R2 secure", 8'h00);
    secure = 0;

    finish_run();
  end
endmodule